// File: doc/BRIEF.md
# Big-Endian Store Byte-Lane Encoder

This block sits between a processor's store path and a 32-bit big-endian data bus. For every store it takes the access size, the two low address bits and the register operand. It returns three things: the byte enables for the bus, the bus data with the operand steered into the addressed lanes, and flags that report an illegal request. The block is purely combinational, so all outputs follow the inputs within the same cycle.

Lane numbering is big-endian. Byte offset 0 within the word is the most significant lane, bits 31:24, and its enable is bit 3. Offset 3 is the least significant lane, bits 7:0, with enable bit 0. The size code is 2'b00 for a byte, 2'b01 for a halfword and 2'b10 for a word. Code 2'b11 is reserved.

A store must be naturally aligned. If it is not, or if the size code is reserved, the block raises the matching flag. No enable is then asserted and the bus data is all zero, so the request cannot reach memory.

Top module: `be_store_lane_enc`

## Requirements
- R1: With size 2'b10 and offset 0, the enables are 4'hF and the bus data equals the operand unchanged.
- R2: With size 2'b01 and offset 0, the enables are 4'hC and bus bits 31:16 carry operand bits 15:0, while bits 15:0 are zero.
- R3: With size 2'b01 and offset 2, the enables are 4'h3 and bus bits 15:0 carry operand bits 15:0, while bits 31:16 are zero.
- R4: With size 2'b00, offsets 0, 1, 2 and 3 give enables 4'h8, 4'h4, 4'h2 and 4'h1, so exactly one enable is set.
- R5: A byte store places operand bits 7:0 shifted left by 24, 16, 8 or 0 bits for offsets 0 through 3, and all other bus bits are zero.
- R6: A word store at any nonzero offset raises the misalignment flag, with enables 0 and bus data 0.
- R7: A halfword store at offset 1 or 3 (address bit 0 set) raises the misalignment flag, with enables 0 and bus data 0.
- R8: Size code 2'b11 raises the size-error flag and leaves the misalignment flag low, with enables 0 and bus data 0, for every offset.
- R9: Every bus lane whose enable is clear carries zero.
- R10: The two flags are never high together, and the enables are nonzero exactly when both flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| addr_lo_i | input | 2 | Byte offset of the store within the 32-bit word |
| wdata_i | input | 32 | Register operand, right-justified |
| lane_en_o | output | 4 | Byte enables; bit 3 is offset 0 (bits 31:24) |
| bus_data_o | output | 32 | Bus data with the operand in the addressed lanes |
| misalign_o | output | 1 | Access is not naturally aligned |
| bad_size_o | output | 1 | Size code is reserved |

## Verification
The alignment check and the lane placement are evaluated in the same cycle. A misaligned halfword or word therefore reaches the lane logic with a span that would hit real lanes, and the check must suppress both enables and data at once. The bench provokes this with every size crossed with every offset, and with random operands whose lanes are all nonzero. A leaked byte then shows up as a nonzero lane next to a raised flag. Reserved size codes are crossed with misaligned offsets to confirm that only the size-error flag is raised. Each cycle, every output is compared with a shift-and-mask model.

// File: rtl/be_store_pkg.sv
package be_store_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned OFS_W  = $clog2(LANES);
  localparam int unsigned SPAN_W = OFS_W + 1;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // Number of lanes an access covers; 0 marks a reserved code.
  function automatic logic [SPAN_W-1:0] span_of(acc_size_e sz);
    case (sz)
      SZ_BYTE: span_of = SPAN_W'(1);
      SZ_HALF: span_of = SPAN_W'(2);
      SZ_WORD: span_of = SPAN_W'(4);
      default: span_of = '0;
    endcase
  endfunction

  // Big-endian: lane index l holds byte address (lanes-1-l).
  function automatic logic covers(int unsigned lanes, int unsigned lane,
                                  logic [OFS_W-1:0] ofs, logic [SPAN_W-1:0] span);
    int unsigned addr;
    addr = lanes - 1 - lane;
    covers = (span != '0) && (addr >= int'(ofs)) && (addr < int'(ofs) + int'(span));
  endfunction

  // Operand byte (counted from the LSB) that lands in a covered lane.
  function automatic logic [OFS_W-1:0] src_byte(int unsigned lanes, int unsigned lane,
                                                logic [OFS_W-1:0] ofs, logic [SPAN_W-1:0] span);
    int addr;
    int k;
    addr = int'(lanes) - 1 - int'(lane);
    k    = int'(span) - 1 - (addr - int'(ofs));
    src_byte = OFS_W'(k);
  endfunction

endpackage

// File: rtl/be_size_check.sv
module be_size_check
  import be_store_pkg::*;
#(
  parameter int unsigned OW = OFS_W,
  parameter int unsigned SW = SPAN_W
) (
  input  acc_size_e       size_i,
  input  logic [OW-1:0]   ofs_i,
  output logic [SW-1:0]   span_o,
  output logic            acc_ok_o,
  output logic            misalign_o,
  output logic            bad_size_o
);

  logic [SW-1:0] span;
  logic [SW-1:0] ofs_ext;
  logic          off_grid;

  always_comb begin
    span     = span_of(size_i);
    ofs_ext  = SW'(ofs_i);
    off_grid = (span != '0) && ((ofs_ext & (span - SW'(1))) != '0);
  end

  assign span_o     = span;
  assign bad_size_o = (span == '0);
  assign misalign_o = off_grid;
  assign acc_ok_o   = (span != '0) && !off_grid;

endmodule

// File: rtl/be_lane_mask.sv
module be_lane_mask
  import be_store_pkg::*;
#(
  parameter int unsigned NL = LANES,
  parameter int unsigned OW = OFS_W,
  parameter int unsigned SW = SPAN_W
) (
  input  logic          acc_ok_i,
  input  logic [OW-1:0] ofs_i,
  input  logic [SW-1:0] span_i,
  output logic [NL-1:0] lane_en_o
);

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign lane_en_o[l] = acc_ok_i && covers(NL, l, ofs_i, span_i);
  end

endmodule

// File: rtl/be_data_place.sv
module be_data_place
  import be_store_pkg::*;
#(
  parameter int unsigned NL = LANES,
  parameter int unsigned LW = LANE_W,
  parameter int unsigned OW = OFS_W,
  parameter int unsigned SW = SPAN_W,
  localparam int unsigned DW = NL * LW
) (
  input  logic [NL-1:0] lane_en_i,
  input  logic [OW-1:0] ofs_i,
  input  logic [SW-1:0] span_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] data_o
);

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [OW-1:0] sel;
    always_comb begin
      sel = src_byte(NL, l, ofs_i, span_i);
      data_o[l*LW +: LW] = lane_en_i[l] ? wdata_i[sel*LW +: LW] : '0;
    end
  end

endmodule

// File: rtl/be_store_lane_enc.sv
module be_store_lane_enc
  import be_store_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [OFS_W-1:0]  addr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  lane_en_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              misalign_o,
  output logic              bad_size_o
);

  acc_size_e          size_e;
  logic [SPAN_W-1:0]  span_w;
  logic               acc_ok_w;
  logic               misalign_w;
  logic               bad_size_w;
  logic [LANES-1:0]   lane_en_w;
  logic [DATA_W-1:0]  placed_w;

  assign size_e = acc_size_e'(size_i);

  be_size_check #(.OW(OFS_W), .SW(SPAN_W)) u_check (
    .size_i     (size_e),
    .ofs_i      (addr_lo_i),
    .span_o     (span_w),
    .acc_ok_o   (acc_ok_w),
    .misalign_o (misalign_w),
    .bad_size_o (bad_size_w)
  );

  be_lane_mask #(.NL(LANES), .OW(OFS_W), .SW(SPAN_W)) u_mask (
    .acc_ok_i  (acc_ok_w),
    .ofs_i     (addr_lo_i),
    .span_i    (span_w),
    .lane_en_o (lane_en_w)
  );

  be_data_place #(.NL(LANES), .LW(LANE_W), .OW(OFS_W), .SW(SPAN_W)) u_place (
    .lane_en_i (lane_en_w),
    .ofs_i     (addr_lo_i),
    .span_i    (span_w),
    .wdata_i   (wdata_i),
    .data_o    (placed_w)
  );

  assign lane_en_o  = lane_en_w;
  assign bus_data_o = placed_w;
  assign misalign_o = misalign_w;
  assign bad_size_o = bad_size_w;

endmodule

// File: rtl/be_store_lane_enc_chk.sv
module be_store_lane_enc_chk
  import be_store_pkg::*;
(
  input logic [1:0]        size_i,
  input logic [OFS_W-1:0]  addr_lo_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [LANES-1:0]  lane_en_o,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              misalign_o,
  input logic              bad_size_o
);

  always_comb begin
    if (!$isunknown({size_i, addr_lo_i, wdata_i})) begin
      if (size_i == 2'b10 && addr_lo_i == '0) begin
        AST_WORD_PASS: assert (lane_en_o == 4'hF && bus_data_o == wdata_i)
          else $error("word store not passed through"); // R1
      end
      if (size_i == 2'b00) begin
        AST_BYTE_ONE_LANE: assert ($countones(lane_en_o) == 1)
          else $error("byte store must enable one lane"); // R4
      end
      if (size_i == 2'b10 && addr_lo_i != '0) begin
        AST_WORD_MISALIGN: assert (misalign_o && lane_en_o == '0 && bus_data_o == '0)
          else $error("misaligned word not blocked"); // R6
      end
      if (size_i == 2'b01 && addr_lo_i[0]) begin
        AST_HALF_MISALIGN: assert (misalign_o && lane_en_o == '0 && bus_data_o == '0)
          else $error("misaligned halfword not blocked"); // R7
      end
      if (size_i == 2'b11) begin
        AST_RSVD_SIZE: assert (bad_size_o && !misalign_o && lane_en_o == '0 && bus_data_o == '0)
          else $error("reserved size not blocked"); // R8
      end
      for (int l = 0; l < int'(LANES); l++) begin
        if (!lane_en_o[l]) begin
          AST_IDLE_LANE_ZERO: assert (bus_data_o[l*LANE_W +: LANE_W] == '0)
            else $error("disabled lane %0d not zero", l); // R9
        end
      end
      AST_FLAGS_EXCLUSIVE: assert (!(misalign_o && bad_size_o))
        else $error("both flags raised"); // R10
      AST_ENABLE_IFF_LEGAL: assert ((lane_en_o != '0) == (!misalign_o && !bad_size_o))
        else $error("enables disagree with flags"); // R10
    end
  end

endmodule

bind be_store_lane_enc be_store_lane_enc_chk u_chk (
  .size_i     (size_i),
  .addr_lo_i  (addr_lo_i),
  .wdata_i    (wdata_i),
  .lane_en_o  (lane_en_o),
  .bus_data_o (bus_data_o),
  .misalign_o (misalign_o),
  .bad_size_o (bad_size_o)
);

// File: tb/be_store_lane_enc_test.sv
`timescale 1ns/1ps
module be_store_lane_enc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic [1:0]  addr_lo_i = 2'b00;
  logic [31:0] wdata_i = 32'h0;
  logic [3:0]  lane_en_o;
  logic [31:0] bus_data_o;
  logic        misalign_o;
  logic        bad_size_o;

  int checks = 0;
  int fails = 0;
  logic chk_en = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  be_store_lane_enc uut (
    .size_i(size_i), .addr_lo_i(addr_lo_i), .wdata_i(wdata_i),
    .lane_en_o(lane_en_o), .bus_data_o(bus_data_o),
    .misalign_o(misalign_o), .bad_size_o(bad_size_o)
  );

  // Shift-and-mask reference model.
  task automatic model(input logic [1:0] sz, input logic [1:0] ofs, input logic [31:0] wd,
                       output logic [3:0] m, output logic [31:0] d,
                       output logic mis, output logic bad);
    int nb;
    int sh;
    longint unsigned v;
    m = 4'h0; d = 32'h0; mis = 1'b0; bad = 1'b0;
    case (sz)
      2'b00: nb = 1;
      2'b01: nb = 2;
      2'b10: nb = 4;
      default: nb = 0;
    endcase
    if (nb == 0) bad = 1'b1;
    else if ((int'(ofs) % nb) != 0) mis = 1'b1;
    else begin
      sh = 4 - int'(ofs) - nb;
      m  = 4'(((1 << nb) - 1) << sh);
      v  = (longint'(wd) & ((64'd1 << (8 * nb)) - 64'd1)) << (8 * sh);
      d  = v[31:0];
    end
  endtask

  function automatic string tag_of(logic [1:0] sz, logic [1:0] ofs);
    case (sz)
      2'b10: tag_of = (ofs == 2'd0) ? "R1" : "R6";
      2'b01: tag_of = ofs[0] ? "R7" : ((ofs == 2'd0) ? "R2" : "R3");
      2'b00: tag_of = "R4/R5";
      default: tag_of = "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (size=%b ofs=%0d wd=%h)",
               req, what, act, exp, size_i, addr_lo_i, wdata_i);
    end
  endtask

  // Compare on every negative edge, half a cycle after the drive.
  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      logic [3:0]  em;
      logic [31:0] ed;
      logic        emis;
      logic        ebad;
      logic [31:0] idle;
      string       t;
      model(size_i, addr_lo_i, wdata_i, em, ed, emis, ebad);
      t = tag_of(size_i, addr_lo_i);
      check(t, "lane_en", 32'(lane_en_o), 32'(em));
      check(t, "bus_data", bus_data_o, ed);
      check(t, "misalign", 32'(misalign_o), 32'(emis));
      check(t, "bad_size", 32'(bad_size_o), 32'(ebad));
      idle = 32'h0;
      for (int l = 0; l < 4; l++)
        if (!lane_en_o[l]) idle[l*8 +: 8] = bus_data_o[l*8 +: 8];
      check("R9", "idle_lanes", idle, 32'h0);
      check("R10", "flags_both", 32'(misalign_o & bad_size_o), 32'h0);
    end
  end

  task automatic drive(input logic [1:0] sz, input logic [1:0] ofs, input logic [31:0] wd);
    @(posedge clk);
    size_i = sz; addr_lo_i = ofs; wdata_i = wd;
    chk_en = 1'b1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2468;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset-state check: all inputs zero is a byte store at offset 0 (R4).
    @(negedge clk);
    check("R4", "idle lane_en", 32'(lane_en_o), 32'h8);
    check("R5", "idle bus_data", bus_data_o, 32'h0);
    // R1 word pass-through, R2/R3 halfwords, R4/R5 byte lanes.
    drive(2'b10, 2'd0, 32'h1234_5678);
    drive(2'b01, 2'd0, 32'hDEAD_BEEF);
    drive(2'b01, 2'd2, 32'hDEAD_BEEF);
    for (int o = 0; o < 4; o++) drive(2'b00, 2'(o), 32'hFFFF_FFA5);
    // R6/R7 misalignment with full-lane operands, R8 reserved size crossed with offsets.
    for (int o = 1; o < 4; o++) drive(2'b10, 2'(o), 32'hFFFF_FFFF);
    drive(2'b01, 2'd1, 32'hFFFF_FFFF);
    drive(2'b01, 2'd3, 32'hFFFF_FFFF);
    for (int o = 0; o < 4; o++) drive(2'b11, 2'(o), 32'hFFFF_FFFF);
    // Exhaustive size x offset with patterned and random data.
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++) begin
        drive(2'(s), 2'(o), 32'h8001_7FFE);
        drive(2'(s), 2'(o), 32'h0000_0000);
      end
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[1:0], lfsr[3:2], lfsr ^ 32'h5A5A_0F0F);
    end
    @(posedge clk);
    @(negedge clk);
    chk_en = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..all actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule